// File: doc/BRIEF.md
# Compare Match Interval Timer

This block is a 16-bit periodic interval timer for a peripheral subsystem. A prescaler divides the peripheral clock by one of four ratios (8, 32, 128 or 512). Each prescaled tick advances an up-counter. When a tick finds the counter equal to a programmable constant, the counter returns to zero and a sticky match flag sets. If interrupts are enabled, the flag also raises an interrupt line. Software sets the period through the constant and starts or stops the timer with a run bit. It acknowledges a match with a read-then-write-zero sequence on the flag.

The design keeps everything in one synchronous clock domain. The prescaler is a free-running divider that emits a one-cycle enable, not a derived clock. There are two reset inputs. Power-on (or standby entry) reset returns every register to its initial value. Manual reset stops the timer and clears the control state, but the counter and the constant keep their contents.

Register addresses: 0 = run register (bit 0 is the start bit), 1 = control/status (bits 1:0 select the clock, bit 6 enables the interrupt, bit 7 is the match flag, other bits read 0), 2 = counter, 3 = constant.

Top module: `match_interval_timer`

## Requirements
- R1: Clock select code 00, 01, 10 and 11 in control/status bits 1:0 gives a divide ratio N of 8, 32, 128 and 512. After the start bit is written to 1, the first counter increment lands exactly N cycles after the writing edge.
- R2: The counter advances only while the start bit (address 0, bit 0) is 1. While it is 0, the counter holds and the prescaler restarts from zero.
- R3: On a tick with the counter equal to the constant, the counter becomes 0x0000 and the match flag (bit 7) sets. The period is therefore (constant+1)·N cycles.
- R4: The interrupt output is high exactly when the match flag and the interrupt enable (bit 6) are both 1.
- R5: Only one sequence clears the match flag: a read of address 1 that sees the flag at 1, followed by a write with bit 7 at 0. A write of 1, or a write of 0 with no prior read, leaves the flag set. A match in the same cycle as the clearing write keeps the flag set.
- R6: Power-on reset sets the counter to 0x0000, the constant to 0xFFFF, control/status to 0x00 and the start bit to 0.
- R7: Manual reset clears the start bit and control/status and ignores bus writes while it is active. It leaves the counter and the constant unchanged.
- R8: The counter (address 2) and the constant (address 3) are readable and writable over all 16 bits.
- R9: A bus write to the counter in the same cycle as a tick takes priority over the increment or the match clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_por | input | 1 | Power-on/standby reset, synchronous, active high |
| rst_man | input | 1 | Manual reset, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the flag clear) |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Compare match interrupt request |

## Verification
The bench places every counter read at a known number of edges after the start write, so its timing checks catch a prescaler that is off by one. Such a prescaler would show the first increment one cycle early or late, or would run at the wrong ratio for one of the select codes. It drives a counter write onto the exact tick edge; a design that let the hardware update win would return 0x0001 or 0x0101 instead of the written value. The flag-clear sequence is probed with a write of 1 and with an unarmed write of 0; a design with a plain write-to-clear flag would drop the match early. A manual reset is issued mid-run with a concurrent write. A design that wiped the counter or constant, or that accepted the write, would read back the wrong values.

// File: rtl/mit_pkg.sv
package mit_pkg;

    localparam int CNT_W     = 16;
    localparam int BASE_LOG2 = 3;
    localparam int STEP_LOG2 = 2;
    localparam int NUM_SEL   = 4;
    localparam int PRE_W     = BASE_LOG2 + STEP_LOG2 * (NUM_SEL - 1);

    typedef enum logic [1:0] {
        SEL_DIV8   = 2'd0,
        SEL_DIV32  = 2'd1,
        SEL_DIV128 = 2'd2,
        SEL_DIV512 = 2'd3
    } clk_sel_e;

    typedef enum logic [1:0] {
        ADR_RUN   = 2'd0,
        ADR_CSR   = 2'd1,
        ADR_COUNT = 2'd2,
        ADR_CONST = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic [3:0] unused;
        clk_sel_e   sel;
    } csr_t;

    function automatic logic [PRE_W-1:0] div_mask(input clk_sel_e s);
        int sh;
        sh = BASE_LOG2 + STEP_LOG2 * int'(s);
        return PRE_W'((1 << sh) - 1);
    endfunction

endpackage

// File: rtl/mit_prescaler.sv
module mit_prescaler
    import mit_pkg::*;
(
    input  logic     clk,
    input  logic     clear,
    input  clk_sel_e sel,
    output logic     tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask = div_mask(sel);

    always_ff @(posedge clk) begin
        if (clear) pre_q <= '0;
        else       pre_q <= pre_q + 1'b1;
    end

    assign tick = !clear && ((pre_q & mask) == mask);
endmodule

// File: rtl/mit_counter.sv
module mit_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_por,
    input  logic         tick,
    input  logic         wr_cnt,
    input  logic         wr_cor,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cor_q,
    output logic         match
);
    logic hit;

    assign hit   = (cnt_q == cor_q);
    assign match = tick && hit && !wr_cnt;

    always_ff @(posedge clk) begin
        if (rst_por) begin
            cnt_q <= '0;
            cor_q <= '1;
        end else begin
            if (wr_cnt)      cnt_q <= wdata;
            else if (tick)   cnt_q <= hit ? '0 : cnt_q + 1'b1;
            if (wr_cor)      cor_q <= wdata;
        end
    end
endmodule

// File: rtl/mit_status.sv
module mit_status (
    input  logic clk,
    input  logic rst,
    input  logic match,
    input  logic rd_csr,
    input  logic wr_csr,
    input  logic wr_flag_bit,
    output logic flag
);
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            armed_q <= 1'b0;
        end else if (match) begin
            flag <= 1'b1;
        end else if (wr_csr && !wr_flag_bit && armed_q) begin
            flag    <= 1'b0;
            armed_q <= 1'b0;
        end else if (rd_csr && flag) begin
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/match_interval_timer.sv
module match_interval_timer
    import mit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_por,
    input  logic              rst_man,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);
    reg_addr_e        radr;
    logic             ctl_rst;
    logic             wr_ok;
    logic             run_q;
    logic             ie_q;
    clk_sel_e         sel_q;
    logic             tick;
    logic             match;
    logic             flag;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cor_q;
    csr_t             csr_view;

    assign radr    = reg_addr_e'(addr);
    assign ctl_rst = rst_por || rst_man;
    assign wr_ok   = wr_en && !rst_man;

    always_ff @(posedge clk) begin
        if (ctl_rst) begin
            run_q <= 1'b0;
            ie_q  <= 1'b0;
            sel_q <= SEL_DIV8;
        end else if (wr_ok) begin
            if (radr == ADR_RUN) run_q <= wdata[0];
            if (radr == ADR_CSR) begin
                ie_q  <= wdata[6];
                sel_q <= clk_sel_e'(wdata[1:0]);
            end
        end
    end

    mit_prescaler u_pre (
        .clk   (clk),
        .clear (ctl_rst || !run_q),
        .sel   (sel_q),
        .tick  (tick)
    );

    mit_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_por (rst_por),
        .tick    (tick),
        .wr_cnt  (wr_ok && radr == ADR_COUNT),
        .wr_cor  (wr_ok && radr == ADR_CONST),
        .wdata   (wdata),
        .cnt_q   (cnt_q),
        .cor_q   (cor_q),
        .match   (match)
    );

    mit_status u_stat (
        .clk         (clk),
        .rst         (ctl_rst),
        .match       (match),
        .rd_csr      (rd_en && !rst_man && radr == ADR_CSR),
        .wr_csr      (wr_ok && radr == ADR_CSR),
        .wr_flag_bit (wdata[7]),
        .flag        (flag)
    );

    always_comb begin
        csr_view = '{flag: flag, ie: ie_q, unused: 4'b0, sel: sel_q};
        unique case (radr)
            ADR_RUN:   rdata = {{(CNT_W-1){1'b0}}, run_q};
            ADR_CSR:   rdata = {{(CNT_W-8){1'b0}}, csr_view};
            ADR_COUNT: rdata = cnt_q;
            default:   rdata = cor_q;
        endcase
    end

    assign irq = flag && ie_q;
endmodule

// File: rtl/mit_checker.sv
module mit_checker (
    input logic        clk,
    input logic        rst_por,
    input logic        rst_man,
    input logic        wr_en,
    input logic [1:0]  addr,
    input logic [15:0] wdata,
    input logic        irq,
    input logic        ie_q,
    input logic        run_q,
    input logic        tick,
    input logic        flag,
    input logic [15:0] cnt_q,
    input logic [15:0] cor_q
);
    logic cnt_wr;
    assign cnt_wr = wr_en && !rst_man && addr == 2'd2;

    assert_match_clears_R3: assert property (@(posedge clk) disable iff (rst_por || rst_man)
        (tick && cnt_q == cor_q && !cnt_wr) |=> (cnt_q == 16'h0000 && flag));

    assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (rst_por)
        irq |-> (flag && ie_q));

    assert_irq_when_enabled_R4: assert property (@(posedge clk) disable iff (rst_por)
        (flag && ie_q) |-> irq);

    assert_hold_stopped_R2: assert property (@(posedge clk) disable iff (rst_por)
        (!run_q && !cnt_wr) |=> $stable(cnt_q));

    assert_manual_keeps_R7: assert property (@(posedge clk) disable iff (rst_por)
        rst_man |=> ($stable(cnt_q) && $stable(cor_q)));

    assert_por_values_R6: assert property (@(posedge clk)
        rst_por |=> (cnt_q == 16'h0000 && cor_q == 16'hFFFF && !flag));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst_por)
        cnt_wr |=> (cnt_q == $past(wdata)));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst_por || rst_man)
        ($fell(flag) && !$past(rst_man)) |-> $past(wr_en && addr == 2'd1 && !wdata[7]));
endmodule

bind match_interval_timer mit_checker u_chk (
    .clk     (clk),
    .rst_por (rst_por),
    .rst_man (rst_man),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .ie_q    (ie_q),
    .run_q   (run_q),
    .tick    (tick),
    .flag    (flag),
    .cnt_q   (cnt_q),
    .cor_q   (cor_q)
);

// File: tb/match_interval_timer_bench.sv
module match_interval_timer_bench;
    logic        clk = 1'b0;
    logic        rst_por = 1'b1;
    logic        rst_man = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [15:0] value;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    event mon_ev;

    always #2.5 clk = ~clk;

    match_interval_timer u_match_interval_timer (
        .clk(clk), .rst_por(rst_por), .rst_man(rst_man), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // monitor: pops the expected item and compares the read result
    initial begin
        forever begin
            exp_t it;
            @(mon_ev);
            it = exp_q.pop_front();
            tests++;
            if (rdata !== it.value) begin
                fails++;
                $display("FAIL %s: rdata actual %h expected %h", it.tag, rdata, it.value);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        exp_t it;
        rd_en = 1'b1; addr = a;
        #1;
        it.value = e; it.tag = tag;
        exp_q.push_back(it);
        ->mon_ev;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        tests++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
        end
    endtask

    // first increment lands N edges after the start write
    task automatic div_probe(input logic [1:0] code, input int n, input string tag);
        bus_wr(2'd0, 16'h0);
        bus_wr(2'd2, 16'h0);
        bus_wr(2'd1, {14'h0, code});
        bus_wr(2'd0, 16'h1);
        idle(n - 1);
        bus_rd(2'd2, 16'h0, tag);
        bus_rd(2'd2, 16'h1, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_por = 1'b0;
        // R6 reset state
        chk_irq(1'b0, "R6 irq");
        bus_rd(2'd2, 16'h0000, "R6 counter");
        bus_rd(2'd3, 16'hFFFF, "R6 constant");
        bus_rd(2'd1, 16'h0000, "R6 csr");
        bus_rd(2'd0, 16'h0000, "R6 run");

        // R1 /8, R3 match, R4 irq, R5 flag clear
        bus_wr(2'd3, 16'd3);
        bus_wr(2'd1, 16'h0040);
        bus_wr(2'd0, 16'h1);           // edge 0
        idle(6);
        bus_rd(2'd2, 16'd0, "R1 div8 k6");
        bus_rd(2'd2, 16'd0, "R1 div8 k7");
        bus_rd(2'd2, 16'd1, "R1 div8 k8");
        idle(22);
        bus_rd(2'd2, 16'd3, "R3 at constant");
        bus_rd(2'd2, 16'd0, "R3 cleared on match");
        chk_irq(1'b1, "R4 irq enabled");
        bus_rd(2'd1, 16'h00C0, "R3 flag set");        // arms clear
        bus_wr(2'd1, 16'h00C0);                       // write 1: no effect
        bus_rd(2'd1, 16'h00C0, "R5 write one keeps flag");
        bus_wr(2'd1, 16'h0040);
        bus_rd(2'd1, 16'h0040, "R5 read then write zero clears");
        chk_irq(1'b0, "R4 irq after clear");

        // R2 hold when stopped, R8 full width
        bus_wr(2'd0, 16'h0);
        bus_wr(2'd2, 16'hA5C3);
        bus_rd(2'd2, 16'hA5C3, "R8 counter rw");
        idle(20);
        bus_rd(2'd2, 16'hA5C3, "R2 stopped holds");
        bus_rd(2'd3, 16'h0003, "R8 constant rw");

        // R1 /32, R4 masked, R5 unarmed write
        bus_wr(2'd2, 16'h0);
        bus_wr(2'd1, 16'h0001);
        bus_wr(2'd0, 16'h1);
        idle(31);
        bus_rd(2'd2, 16'd0, "R1 div32 k31");
        bus_rd(2'd2, 16'd1, "R1 div32 k32");
        idle(95);                                     // match at edge 128
        chk_irq(1'b0, "R4 irq masked");
        bus_wr(2'd1, 16'h0001);                       // no prior read
        bus_rd(2'd1, 16'h0081, "R5 unarmed write keeps flag");
        bus_wr(2'd1, 16'h0041);
        bus_rd(2'd1, 16'h0041, "R5 armed clear");
        chk_irq(1'b0, "R4 irq after clear");

        // R1 /128 and /512
        div_probe(2'd2, 128, "R1 div128");
        div_probe(2'd3, 512, "R1 div512");

        // R9 write on tick edge wins
        bus_wr(2'd0, 16'h0);
        bus_wr(2'd3, 16'h0010);
        bus_wr(2'd2, 16'h0);
        bus_wr(2'd1, 16'h0000);
        bus_wr(2'd0, 16'h1);
        idle(7);
        bus_wr(2'd2, 16'h0100);                       // lands on edge 8
        bus_rd(2'd2, 16'h0100, "R9 write beats tick");

        // R7 manual reset
        bus_wr(2'd0, 16'h0);
        bus_wr(2'd2, 16'h00AB);
        bus_wr(2'd3, 16'h0055);
        bus_wr(2'd1, 16'h0042);
        bus_wr(2'd0, 16'h1);
        rst_man = 1'b1; wr_en = 1'b1; addr = 2'd3; wdata = 16'h1111;
        @(negedge clk);
        rst_man = 1'b0; wr_en = 1'b0;
        bus_rd(2'd2, 16'h00AB, "R7 counter kept");
        bus_rd(2'd3, 16'h0055, "R7 constant kept, write ignored");
        bus_rd(2'd1, 16'h0000, "R7 csr cleared");
        bus_rd(2'd0, 16'h0000, "R7 run cleared");
        idle(20);
        bus_rd(2'd2, 16'h00AB, "R7 stays stopped");

        // R6 power-on reset after activity
        rst_por = 1'b1;
        idle(1);
        rst_por = 1'b0;
        bus_rd(2'd2, 16'h0000, "R6 counter after por");
        bus_rd(2'd3, 16'hFFFF, "R6 constant after por");

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule